// File: doc/BRIEF.md
# Sum-of-Products Logic Macrocell Array

This block is the evaluation core of a programmable logic region. A wide AND plane forms product terms from the true and inverted forms of 64 array signals. Sixteen output macrocells each OR a group of up to ten of those terms. Each macrocell can present its OR result directly or through its own flip-flop. Its result goes back into the AND plane as a feedback signal, which lets a macrocell serve as an internal state bit, and it also leaves the block as a pin value with a matching output enable.

The 64 array signals come from four sources. Sixteen input conditioning cells take port pin values and pass them straight through, register them, or latch them. A feedback field carries the 16 macrocell results. An 8-bit page value and a 24-bit field of external logic inputs fill the rest. The conditioned pin values are also brought out, so the host processor can read them at any time. All configuration is supplied as static input vectors: connection masks, term enables, output mode and input cell mode. The logic that programs those vectors lies outside this block.

Top module: `sop_macro_array`

## Requirements
- R1: A product term is the AND of the literals its mask selects. For macrocell m and term t, the mask bits start at base (m*10+t)*128 in `cfg_pt_mask`. Bit base+k selects array signal k in true form, and bit base+64+k selects it in inverted form. A term whose mask is all zero evaluates to 0.
- R2: A macrocell's OR result is 1 when any of its enabled terms is 1. Term t of macrocell m is enabled by bit m*10+t of `cfg_pt_en`. A disabled term contributes 0 whatever its mask holds.
- R3: When bit m of `cfg_mc_reg` is 1, `mc_out[m]` shows the OR result captured at the previous rising clock edge. When the bit is 0, `mc_out[m]` follows the OR result in the same cycle.
- R4: Array signal 16+m carries the result of macrocell m back into the AND plane. The same-cycle OR result is seen only by higher-numbered macrocells, and only when macrocell m is combinational. Macrocell m itself, the lower-numbered macrocells, and every reader when macrocell m is registered all see its flip-flop value. This makes a combinational feedback loop impossible.
- R5: Array signals 0 to 15 are the conditioned input cell values, 32 to 39 are `page_in[0..7]`, and 40 to 63 are `ext_in[0..23]`.
- R6: Field `cfg_imc_mode[2i+1:2i]` sets the mode of input cell i. Code 0 passes the pin through in the same cycle. Code 1 gives the pin value sampled at the previous rising edge. Code 3 behaves as code 0.
- R7: With code 2, input cell i is transparent while `imc_le[i]` is high. While `imc_le[i]` is low, the cell holds the pin value from the last rising edge at which the enable was high.
- R8: `imc_val` always shows the conditioned input cell values, which are the same values the AND plane uses.
- R9: `mc_out` is the pin value of each macrocell, and `pin_oe` equals `cfg_mc_oe` bit for bit.
- R10: While `rst_n` is low, all macrocell and input cell flip-flops are cleared asynchronously. After `rst_n` rises at a falling edge, the flip-flops first capture at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Port pin values entering the input cells |
| imc_le | input | 16 | Latch enable for each input cell in latch mode |
| page_in | input | 8 | Page value fed to the array |
| ext_in | input | 24 | Additional external logic inputs to the array |
| cfg_imc_mode | input | 32 | Two-bit mode code for each input cell |
| cfg_pt_mask | input | 20480 | Connection mask, 128 bits per product term |
| cfg_pt_en | input | 160 | Enable bit for each product term |
| cfg_mc_reg | input | 16 | Registered (1) or combinational (0) output for each macrocell |
| cfg_mc_oe | input | 16 | Pin output enable for each macrocell |
| imc_val | output | 16 | Conditioned input cell values, readable at any time |
| mc_out | output | 16 | Macrocell results and pin values |
| pin_oe | output | 16 | Pin output enables |

## Verification
Results arrive at different times. Combinational macrocells and pass-through or open-latch input cells respond in the same cycle as their inputs. Registered macrocells and clocked input cells respond one rising edge later. A chain of a clocked input cell into a registered macrocell takes two edges, and the first capture after reset release is at the third edge. The bench drives each stimulus at a falling edge and pushes the expected values for that cycle into a scoreboard. It keeps its own model of every flip-flop and steps that model at each rising edge. The monitor compares 2 ns after the same falling edge, which is settled for same-cycle results and still before the next capture.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    IMC_PASS  = 2'd0,
    IMC_CLK   = 2'd1,
    IMC_LATCH = 2'd2,
    IMC_ALT   = 2'd3
  } imc_mode_e;

endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q = sync_q[1];

endmodule

// File: rtl/sop_in_cell.sv
module sop_in_cell
  import sop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_q,
  input  logic      pin,
  input  logic      le,
  input  imc_mode_e mode,
  output logic      val
);

  logic clk_q, clk_en;
  logic hold_q, hold_en;

  // Clock enables: each storage bit only toggles in the mode that uses it.
  always_comb begin
    clk_en  = (mode == IMC_CLK);
    hold_en = (mode == IMC_LATCH) && le;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      clk_q <= 1'b0;
    end else if (clk_en) begin
      clk_q <= pin;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hold_q <= 1'b0;
    end else if (hold_en) begin
      hold_q <= pin;
    end
  end

  always_comb begin
    unique case (mode)
      IMC_CLK:   val = clk_q;
      IMC_LATCH: val = le ? pin : hold_q;
      default:   val = pin;
    endcase
  end

endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
  parameter int N_IN = 64,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [LIT_W-1:0] lits,
  input  logic [LIT_W-1:0] mask,
  output logic             term
);

  logic any_sel;
  logic all_true;

  always_comb begin
    any_sel  = |mask;
    all_true = &(lits | ~mask);
    term     = any_sel & all_true;
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell #(
  parameter int N_IN = 64,
  parameter int N_PT = 10,
  localparam int LIT_W  = 2 * N_IN,
  localparam int MASK_W = N_PT * LIT_W
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic [N_IN-1:0]   arr_in,
  input  logic [MASK_W-1:0] mask,
  input  logic [N_PT-1:0]   pt_en,
  input  logic              reg_sel,
  output logic              or_res,
  output logic              q,
  output logic              out
);

  logic [LIT_W-1:0] lits;
  logic [N_PT-1:0]  pt;
  logic             q_d;

  assign lits = {~arr_in, arr_in};

  for (genvar gt = 0; gt < N_PT; gt++) begin : g_pt
    sop_pterm #(.N_IN(N_IN)) u_pterm (
      .lits (lits),
      .mask (mask[gt*LIT_W +: LIT_W]),
      .term (pt[gt])
    );
  end

  always_comb begin
    or_res = |(pt & pt_en);
    q_d    = or_res;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end

  assign out = reg_sel ? q : or_res;

endmodule

// File: rtl/sop_macro_array.sv
module sop_macro_array
  import sop_pkg::*;
#(
  parameter int N_IN   = 64,
  parameter int N_IMC  = 16,
  parameter int N_OMC  = 16,
  parameter int N_PT   = 10,
  parameter int PAGE_W = 8,
  localparam int N_EXT     = N_IN - N_IMC - N_OMC - PAGE_W,
  localparam int LIT_W     = 2 * N_IN,
  localparam int MC_MASK_W = N_PT * LIT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IMC-1:0]             pin_in,
  input  logic [N_IMC-1:0]             imc_le,
  input  logic [PAGE_W-1:0]            page_in,
  input  logic [N_EXT-1:0]             ext_in,
  input  logic [2*N_IMC-1:0]           cfg_imc_mode,
  input  logic [N_OMC*MC_MASK_W-1:0]   cfg_pt_mask,
  input  logic [N_OMC*N_PT-1:0]        cfg_pt_en,
  input  logic [N_OMC-1:0]             cfg_mc_reg,
  input  logic [N_OMC-1:0]             cfg_mc_oe,
  output logic [N_IMC-1:0]             imc_val,
  output logic [N_OMC-1:0]             mc_out,
  output logic [N_OMC-1:0]             pin_oe
);

  logic             rst_q;
  logic [N_OMC-1:0] or_res;
  logic [N_OMC-1:0] mc_q;

  sop_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar gi = 0; gi < N_IMC; gi++) begin : g_in
    sop_in_cell u_in (
      .clk   (clk),
      .rst_q (rst_q),
      .pin   (pin_in[gi]),
      .le    (imc_le[gi]),
      .mode  (imc_mode_e'(cfg_imc_mode[2*gi +: 2])),
      .val   (imc_val[gi])
    );
  end

  for (genvar gm = 0; gm < N_OMC; gm++) begin : g_mc
    logic [N_OMC-1:0] fb;
    logic [N_IN-1:0]  arr;

    // Triangular feedback: same-cycle results only flow to higher indices.
    for (genvar gf = 0; gf < N_OMC; gf++) begin : g_fb
      if (gf < gm) begin : g_fwd
        assign fb[gf] = cfg_mc_reg[gf] ? mc_q[gf] : or_res[gf];
      end else begin : g_reg
        assign fb[gf] = mc_q[gf];
      end
    end

    assign arr = {ext_in, page_in, fb, imc_val};

    sop_out_cell #(.N_IN(N_IN), .N_PT(N_PT)) u_oc (
      .clk     (clk),
      .rst_q   (rst_q),
      .arr_in  (arr),
      .mask    (cfg_pt_mask[gm*MC_MASK_W +: MC_MASK_W]),
      .pt_en   (cfg_pt_en[gm*N_PT +: N_PT]),
      .reg_sel (cfg_mc_reg[gm]),
      .or_res  (or_res[gm]),
      .q       (mc_q[gm]),
      .out     (mc_out[gm])
    );
  end

  assign pin_oe = cfg_mc_oe;

endmodule

module sop_macro_array_chk #(
  parameter int N_IMC = 16,
  parameter int N_OMC = 16
) (
  input logic               clk,
  input logic               rst_q,
  input logic [N_IMC-1:0]   pin_in,
  input logic [N_IMC-1:0]   imc_le,
  input logic [2*N_IMC-1:0] cfg_imc_mode,
  input logic [N_OMC-1:0]   cfg_mc_reg,
  input logic [N_OMC-1:0]   or_res,
  input logic [N_OMC-1:0]   mc_q,
  input logic [N_IMC-1:0]   imc_val,
  input logic [N_OMC-1:0]   mc_out
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_q |-> mc_q == '0); // R10

  for (genvar m = 0; m < N_OMC; m++) begin : g_mc_chk
    AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_q)
      (cfg_mc_reg[m] && $past(rst_q) && $stable(cfg_mc_reg))
      |-> mc_out[m] == $past(or_res[m])); // R3
  end

  for (genvar i = 0; i < N_IMC; i++) begin : g_in_chk
    AST_IMC_CLOCKED: assert property (@(posedge clk) disable iff (!rst_q)
      (cfg_imc_mode[2*i +: 2] == 2'd1 && $past(rst_q) && $stable(cfg_imc_mode))
      |-> imc_val[i] == $past(pin_in[i])); // R6
    AST_IMC_PASS: assert property (@(posedge clk) disable iff (!rst_q)
      (cfg_imc_mode[2*i +: 2] == 2'd0 || cfg_imc_mode[2*i +: 2] == 2'd3)
      |-> imc_val[i] == pin_in[i]); // R6
    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_q)
      (cfg_imc_mode[2*i +: 2] == 2'd2 && imc_le[i])
      |-> imc_val[i] == pin_in[i]); // R7
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
      (cfg_imc_mode[2*i +: 2] == 2'd2 && !imc_le[i] && !$past(imc_le[i])
       && $past(rst_q) && $stable(cfg_imc_mode))
      |-> $stable(imc_val[i])); // R7
  end

endmodule

bind sop_macro_array sop_macro_array_chk #(.N_IMC(N_IMC), .N_OMC(N_OMC)) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .pin_in       (pin_in),
  .imc_le       (imc_le),
  .cfg_imc_mode (cfg_imc_mode),
  .cfg_mc_reg   (cfg_mc_reg),
  .or_res       (or_res),
  .mc_q         (mc_q),
  .imc_val      (imc_val),
  .mc_out       (mc_out)
);

// File: tb/sop_macro_array_tb.sv
module sop_macro_array_tb;

  localparam int N_IN   = 64;
  localparam int N_IMC  = 16;
  localparam int N_OMC  = 16;
  localparam int N_PT   = 10;
  localparam int PAGE_W = 8;
  localparam int N_EXT  = N_IN - N_IMC - N_OMC - PAGE_W;
  localparam int LIT_W  = 2 * N_IN;
  localparam int MASK_W = N_OMC * N_PT * LIT_W;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [N_IMC-1:0]     pin_in, imc_le;
  logic [PAGE_W-1:0]    page_in;
  logic [N_EXT-1:0]     ext_in;
  logic [2*N_IMC-1:0]   cfg_imc_mode;
  logic [MASK_W-1:0]    cfg_pt_mask;
  logic [N_OMC*N_PT-1:0] cfg_pt_en;
  logic [N_OMC-1:0]     cfg_mc_reg, cfg_mc_oe;
  logic [N_IMC-1:0]     imc_val;
  logic [N_OMC-1:0]     mc_out, pin_oe;

  always #4 clk = ~clk;

  sop_macro_array u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .imc_le(imc_le),
    .page_in(page_in), .ext_in(ext_in), .cfg_imc_mode(cfg_imc_mode),
    .cfg_pt_mask(cfg_pt_mask), .cfg_pt_en(cfg_pt_en),
    .cfg_mc_reg(cfg_mc_reg), .cfg_mc_oe(cfg_mc_oe),
    .imc_val(imc_val), .mc_out(mc_out), .pin_oe(pin_oe)
  );

  typedef struct {
    logic [N_OMC-1:0] mc;
    logic [N_IMC-1:0] imc;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Bench model state, built from the requirements.
  logic [N_OMC-1:0] m_q, m_orr, m_exp;
  logic [N_IMC-1:0] m_iq, m_ih, m_imc;
  logic [1:0]       m_rs;
  logic [31:0]      lf = 32'h1ACE_5EED;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic set_lit(input int m, input int t, input int idx, input bit neg);
    cfg_pt_mask[(m*N_PT+t)*LIT_W + (neg ? N_IN : 0) + idx] = 1'b1;
    cfg_pt_en[m*N_PT+t] = 1'b1;
  endtask

  task automatic model_eval();
    logic [N_IN-1:0] v;
    logic any_sel, all_t, lv, orr;
    for (int i = 0; i < N_IMC; i++) begin
      case (cfg_imc_mode[2*i +: 2])
        2'd1:    m_imc[i] = m_iq[i];
        2'd2:    m_imc[i] = imc_le[i] ? pin_in[i] : m_ih[i];
        default: m_imc[i] = pin_in[i];
      endcase
    end
    for (int m = 0; m < N_OMC; m++) begin
      v[N_IMC-1:0] = m_imc;
      for (int i = 0; i < N_OMC; i++)
        v[N_IMC+i] = (i < m && !cfg_mc_reg[i]) ? m_orr[i] : m_q[i];
      v[N_IMC+N_OMC +: PAGE_W]        = page_in;
      v[N_IMC+N_OMC+PAGE_W +: N_EXT]  = ext_in;
      orr = 1'b0;
      for (int t = 0; t < N_PT; t++) begin
        if (cfg_pt_en[m*N_PT+t]) begin
          any_sel = 1'b0;
          all_t   = 1'b1;
          for (int k = 0; k < LIT_W; k++) begin
            if (cfg_pt_mask[(m*N_PT+t)*LIT_W + k]) begin
              any_sel = 1'b1;
              lv = (k < N_IN) ? v[k] : ~v[k-N_IN];
              if (!lv) all_t = 1'b0;
            end
          end
          if (any_sel && all_t) orr = 1'b1;
        end
      end
      m_orr[m] = orr;
      m_exp[m] = cfg_mc_reg[m] ? m_q[m] : orr;
    end
  endtask

  // Driver: applies one cycle of stimulus, pushes expectations, steps model.
  task automatic drive(input logic [N_IMC-1:0] pin, input logic [N_IMC-1:0] le,
                       input logic [PAGE_W-1:0] pg, input logic [N_EXT-1:0] ex,
                       input bit rst, input string tag);
    exp_t e;
    @(negedge clk);
    pin_in = pin; imc_le = le; page_in = pg; ext_in = ex; rst_n = rst;
    if (!rst) begin
      m_q = '0; m_iq = '0; m_ih = '0; m_rs = 2'b00;
    end
    model_eval();
    e.mc = m_exp; e.imc = m_imc; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    if (rst && m_rs[1]) begin
      m_q  = m_orr;
      m_iq = pin_in;
      m_ih = (imc_le & pin_in) | (~imc_le & m_ih);
    end
    m_rs = rst ? {m_rs[0], 1'b1} : 2'b00;
  endtask

  task automatic rnd_cycle(input bit rst, input string tag);
    logic [31:0] a, b;
    lf = lfsr_next(lf); a = lf;
    lf = lfsr_next(lf); b = lf;
    drive(a[15:0], a[31:16], b[7:0], {b[31:8]}, rst, tag);
  endtask

  // Monitor: pops expectations and compares once same-cycle paths settle.
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (mc_out !== e.mc) begin
          fails++;
          $display("FAIL %s mc_out actual=%h expected=%h", e.tag, mc_out, e.mc);
        end
        checks++;
        if (imc_val !== e.imc) begin
          fails++;
          $display("FAIL %s imc_val actual=%h expected=%h", e.tag, imc_val, e.imc);
        end
        checks++;
        if (pin_oe !== cfg_mc_oe) begin
          fails++;
          $display("FAIL R9 pin_oe actual=%h expected=%h", pin_oe, cfg_mc_oe);
        end
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin : main
    logic [5:0] r3_pat;
    rst_n = 1'b1;
    pin_in = '0; imc_le = '0; page_in = '0; ext_in = '0;
    cfg_pt_mask = '0; cfg_pt_en = '0;
    cfg_imc_mode = '0;
    cfg_imc_mode[3:2] = 2'd1;   // input cell 1 clocked
    cfg_imc_mode[5:4] = 2'd2;   // input cell 2 latched
    cfg_imc_mode[7:6] = 2'd3;   // input cell 3 alternate pass
    set_lit(0, 0, 40, 0); set_lit(0, 0, 41, 1);
    cfg_pt_en[1*N_PT+0] = 1'b1;                 // enabled but empty term
    set_lit(2, 0, 42, 0); set_lit(2, 9, 43, 0);
    set_lit(2, 5, 44, 0); cfg_pt_en[2*N_PT+5] = 1'b0;
    set_lit(3, 0, 45, 0);
    set_lit(4, 0, 46, 0); set_lit(5, 0, 20, 0);  // mc5 reads comb mc4
    set_lit(6, 0, 19, 0);                         // mc6 reads registered mc3
    set_lit(7, 0, 24, 0); set_lit(8, 0, 47, 0);  // mc7 reads higher mc8
    set_lit(9, 0, 35, 0); set_lit(9, 0, 63, 0);
    set_lit(10, 0, 1, 0);
    set_lit(11, 0, 2, 0);
    set_lit(12, 0, 28, 1);                        // self-toggling
    set_lit(13, 0, 3, 1);
    set_lit(14, 0, 0, 0); set_lit(14, 1, 2, 0);
    cfg_mc_reg = 16'h1808;
    cfg_mc_oe  = 16'hA5C3;
    m_q = '0; m_iq = '0; m_ih = '0; m_rs = 2'b00; m_orr = '0;
    #1 rst_n = 1'b0;

    for (int k = 0; k < 3; k++) drive('0, '0, '0, '0, 1'b0, "R10 reset state");
    for (int k = 0; k < 4; k++) drive('0, '0, '0, '0, 1'b1, "R10 release");

    for (int k = 0; k < 4; k++)
      drive('0, '0, '0, N_EXT'(k), 1'b1, "R1 term AND and empty term");
    for (int k = 0; k < 8; k++)
      drive('0, '0, '0, N_EXT'(k) << 2, 1'b1, "R2 OR of enabled terms");
    r3_pat = 6'b001011;
    for (int k = 0; k < 6; k++)
      drive('0, '0, '0, N_EXT'(r3_pat[k]) << 5, 1'b1, "R3 registered vs combinational");
    for (int k = 0; k < 8; k++)
      drive('0, '0, '0, (N_EXT'(k & 1) << 6) | (N_EXT'((k >> 1) & 1) << 7), 1'b1,
            "R4 feedback ordering");
    for (int k = 0; k < 8; k++)
      drive('0, '0, (k & 1) ? 8'h08 : 8'h00, N_EXT'((k >> 1) & 1) << 23, 1'b1,
            "R5 page and external inputs");
    for (int k = 0; k < 8; k++) begin
      lf = lfsr_next(lf);
      drive(lf[15:0], '0, '0, '0, 1'b1, "R6 R8 input cell modes");
    end
    for (int k = 0; k < 10; k++) begin
      lf = lfsr_next(lf);
      drive(lf[15:0], (k % 3 == 0) ? '1 : '0, '0, '0, 1'b1, "R7 latch open and hold");
    end
    for (int k = 0; k < 120; k++) rnd_cycle(1'b1, "R2 R4 R6 mixed random");
    for (int k = 0; k < 2; k++) rnd_cycle(1'b0, "R10 reset mid-run");
    for (int k = 0; k < 40; k++) rnd_cycle(1'b1, "R10 R3 after release");

    @(negedge clk);
    #3;
    done = 1;
    report();
    $finish;
  end

endmodule